// File: doc/BRIEF.md
# SPI Configuration Register Port

This block is the serial slave front end of a radio transceiver's configuration registers. An external host runs SPI mode 0 transactions. While the host shifts in the command byte, the block shifts out the current status byte. The second byte then either returns the addressed register or writes it. A dedicated opcode followed by a fixed key byte flips between two register banks. All pins are oversampled in the system clock domain, so every register and flag lives in one clock domain.

Three configuration registers are held here: retry setup, channel and RF setup. Their fields leave the block as plain outputs. The status register merges two sticky interrupt flags with live inputs: the receive-pipe number and the transmit-full level. The interrupt flags clear when a 1 is written to them.

Top module: `spi_regport`

## Requirements
- R1: During the first byte of each transaction, MISO carries a status byte MSB first. The byte is captured when CSN low is recognised. Its layout is bit 7 bank, bit 6 rx-ready flag, bit 5 zero, bit 4 max-retry flag, bits 3:1 receive pipe input, bit 0 tx-full input. After reset, with pipe input 111 and tx-full 0, it reads 0x0E.
- R2: The port uses SPI mode 0, MSB first. MOSI is sampled on the rising SCK edge and MISO changes only after a falling SCK edge or the start of a transaction. A command of 000AAAAA reads address AAAAA and 001AAAAA writes it.
- R3: In a read, the second byte on MISO is the addressed register's value at the end of the command byte.
- R4: A write takes effect on the (SYNC_STAGES+1)-th clock edge after the SCK rise that completes the data byte. The register addresses and reset values are: 0x04 retry setup = 0x03 (bits 7:4 delay, 3:0 count), 0x05 channel = 0x02, 0x06 RF setup = 0x0F.
- R5: Channel bit 7 and RF setup bits 7:6 ignore writes and always read 0.
- R6: The RF setup fields are bit 5 rate-low, bit 4 force-lock, bit 3 rate-high, bits 2:1 power and bit 0 high LNA gain. The rate output is {bit5, bit3}.
- R7: Writing status (0x07) clears bit 6 and/or bit 4 where the data bit is 1. All other status bits ignore writes.
- R8: An event that sets a flag on the same clock edge as a clear of that flag leaves the flag set.
- R9: Opcode 0x50 followed by data byte 0x53 toggles the bank, shown in status bit 7. Any other data byte after 0x50 leaves the bank unchanged.
- R10: In bank 1, addresses 0x04–0x06 read 0 and ignore writes, while status stays accessible. Unmapped addresses read 0 in both banks.
- R11: CSN high aborts a transaction. A write cut short before its 16th rising SCK edge changes nothing, and the next transaction starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| rxReadyEvt | input | 1 | Pulse: new receive payload arrived |
| maxRetryEvt | input | 1 | Pulse: retry limit reached |
| rxPipe | input | 3 | Pipe number of next receive payload, 111 when empty |
| txFull | input | 1 | Transmit FIFO full level |
| miso | output | 1 | Serial data to host |
| retryDelay | output | 4 | Retry delay field |
| retryCount | output | 4 | Retry count field |
| channel | output | 7 | Channel number |
| dataRate | output | 2 | {rate-low, rate-high} |
| pllForce | output | 1 | Force-lock test bit |
| txPower | output | 2 | Output power select |
| lnaHighGain | output | 1 | LNA gain select |
| bankSel | output | 1 | Selected register bank |

## Verification
A wrong bit counter or a stale shift register shows up on MISO within one byte as a mis-shifted status value, or at the outputs as a register loaded with a shifted data byte. A wrong flag priority or a wrong bank only appears in the next transaction's status byte, so the bench reads status after every flag or bank action. Sweeping a pulse's position across the write-strobe cycle pins the set-over-clear ordering to a single clock.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_RETRY  = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_CHAN   = 5'h05;
  localparam logic [ADDR_W-1:0] ADDR_RF     = 5'h06;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'h07;

  localparam logic [2:0]        OPC_READ     = 3'b000;
  localparam logic [2:0]        OPC_WRITE    = 3'b001;
  localparam logic [DATA_W-1:0] OP_ACTIVATE  = 8'h50;
  localparam logic [DATA_W-1:0] ACTIVATE_KEY = 8'h53;

  typedef struct packed {
    logic              wrEn;
    logic              bankToggle;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_DONE
  } xferState_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic mosiIn,
  output logic sckRise,
  output logic sckFall,
  output logic csHigh,
  output logic csFall,
  output logic mosiBit
);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] PIN_RST = 3'b100;  // {csN, sck, mosi}

  logic [NPINS-1:0] pinRaw;
  logic [NPINS-1:0] pinSync;
  logic             sckPrev;
  logic             csPrev;

  assign pinRaw = {csNIn, sckIn, mosiIn};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{PIN_RST[p]}};
      else       chain <= {chain[STAGES-2:0], pinRaw[p]};
    end
    assign pinSync[p] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= pinSync[1];
      csPrev  <= pinSync[2];
    end
  end

  assign sckRise = pinSync[1] && !sckPrev;
  assign sckFall = !pinSync[1] && sckPrev;
  assign csHigh  = pinSync[2];
  assign csFall  = !pinSync[2] && csPrev;
  assign mosiBit = pinSync[0];

  initial begin
    assert (STAGES >= 2) else $error("STAGES must be at least 2");
  end
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csHigh,
  input  logic              csFall,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] statusByte,
  input  logic [DATA_W-1:0] rdData,
  output ctrlStrobe_t       strobe,
  output logic              miso
);
  xferState_t        state;
  logic [2:0]        bitCnt;
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] txShift;
  logic              loadPending;

  logic [DATA_W-1:0] rxByte;
  logic              byteEnd;
  logic              cmdIsRead;
  logic              cmdIsWrite;
  logic              cmdIsAct;
  logic [DATA_W-1:0] txLoad;

  assign rxByte     = {rxShift, mosiBit};
  assign byteEnd    = sckRise && (bitCnt == 3'd7);
  assign cmdIsRead  = (cmdReg[7:5] == OPC_READ);
  assign cmdIsWrite = (cmdReg[7:5] == OPC_WRITE);
  assign cmdIsAct   = (cmdReg == OP_ACTIVATE);
  assign txLoad     = cmdIsRead ? rdData : '0;

  always_comb begin
    strobe.addr       = cmdReg[ADDR_W-1:0];
    strobe.data       = rxByte;
    strobe.wrEn       = (state == ST_DATA) && byteEnd && cmdIsWrite;
    strobe.bankToggle = (state == ST_DATA) && byteEnd && cmdIsAct && (rxByte == ACTIVATE_KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      rxShift     <= '0;
      cmdReg      <= '0;
      txShift     <= '0;
      loadPending <= 1'b0;
    end else if (csHigh) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      txShift     <= '0;
      loadPending <= 1'b0;
    end else if (csFall) begin
      state       <= ST_CMD;
      bitCnt      <= '0;
      txShift     <= statusByte;
      loadPending <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sckRise) begin
        bitCnt  <= bitCnt + 3'd1;
        rxShift <= rxByte[DATA_W-2:0];
        if (bitCnt == 3'd7) begin
          case (state)
            ST_CMD: begin
              cmdReg      <= rxByte;
              state       <= ST_DATA;
              loadPending <= 1'b1;
            end
            ST_DATA: state <= ST_DONE;
            default: state <= state;
          endcase
        end
      end
      if (sckFall) begin
        if (loadPending) begin
          txShift     <= txLoad;
          loadPending <= 1'b0;
        end else begin
          txShift <= {txShift[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = txShift[DATA_W-1];

  AST_MISO_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!sckFall && !csFall && !csHigh) |=> $stable(miso)) else $error("miso moved off a falling edge"); // R2

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEn, strobe.bankToggle})) else $error("write and bank toggle together"); // R9

  AST_NO_ACTION_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |-> !strobe.wrEn && !strobe.bankToggle) else $error("action outside transaction"); // R11
endmodule

// File: rtl/cfg_reg_datapath.sv
module cfg_reg_datapath
  import regport_pkg::*;
#(
  parameter logic [6:0] CHAN_RESET  = 7'd2,
  parameter logic [7:0] RETRY_RESET = 8'h03,
  parameter logic [5:0] RF_RESET    = 6'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              rxReadyEvt,
  input  logic              maxRetryEvt,
  input  logic [2:0]        rxPipe,
  input  logic              txFull,
  output logic [DATA_W-1:0] statusByte,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        retryReg,
  output logic [6:0]        chanReg,
  output logic [5:0]        rfReg,
  output logic              bank
);
  localparam int RX_FLAG_BIT  = 6;
  localparam int MAX_FLAG_BIT = 4;

  logic rxFlag;
  logic maxFlag;
  logic bank0Sel;
  logic hitStatus;
  logic clrRx;
  logic clrMax;

  assign bank0Sel  = !bank;
  assign hitStatus = strobe.wrEn && (strobe.addr == ADDR_STATUS);
  assign clrRx     = hitStatus && strobe.data[RX_FLAG_BIT];
  assign clrMax    = hitStatus && strobe.data[MAX_FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryReg <= RETRY_RESET;
      chanReg  <= CHAN_RESET;
      rfReg    <= RF_RESET;
    end else if (strobe.wrEn && bank0Sel) begin
      case (strobe.addr)
        ADDR_RETRY: retryReg <= strobe.data;
        ADDR_CHAN:  chanReg  <= strobe.data[6:0];
        ADDR_RF:    rfReg    <= strobe.data[5:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFlag  <= 1'b0;
      maxFlag <= 1'b0;
      bank    <= 1'b0;
    end else begin
      if (rxReadyEvt)       rxFlag  <= 1'b1;
      else if (clrRx)       rxFlag  <= 1'b0;
      if (maxRetryEvt)      maxFlag <= 1'b1;
      else if (clrMax)      maxFlag <= 1'b0;
      if (strobe.bankToggle) bank   <= !bank;
    end
  end

  assign statusByte = {bank, rxFlag, 1'b0, maxFlag, rxPipe, txFull};

  always_comb begin
    case (strobe.addr)
      ADDR_RETRY:  rdData = bank0Sel ? retryReg : '0;
      ADDR_CHAN:   rdData = bank0Sel ? {1'b0, chanReg} : '0;
      ADDR_RF:     rdData = bank0Sel ? {2'b00, rfReg} : '0;
      ADDR_STATUS: rdData = statusByte;
      default:     rdData = '0;
    endcase
  end

  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rxReadyEvt |=> statusByte[RX_FLAG_BIT]) else $error("rx flag lost its set"); // R8

  AST_MAX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    maxRetryEvt |=> statusByte[MAX_FLAG_BIT]) else $error("max flag lost its set"); // R8

  AST_RX_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrRx && !rxReadyEvt) |=> !statusByte[RX_FLAG_BIT]) else $error("rx flag not cleared"); // R7

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bankToggle |=> $stable(bank)) else $error("bank moved without key"); // R9

  AST_BANK1_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (bank && strobe.wrEn) |=> $stable(retryReg) && $stable(chanReg) && $stable(rfReg))
    else $error("bank 1 write reached bank 0 register"); // R10
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import regport_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] CHAN_RESET  = 7'd2,
  parameter logic [7:0] RETRY_RESET = 8'h03,
  parameter logic [5:0] RF_RESET    = 6'h0F
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       mosi,
  input  logic       rxReadyEvt,
  input  logic       maxRetryEvt,
  input  logic [2:0] rxPipe,
  input  logic       txFull,
  output logic       miso,
  output logic [3:0] retryDelay,
  output logic [3:0] retryCount,
  output logic [6:0] channel,
  output logic [1:0] dataRate,
  output logic       pllForce,
  output logic [1:0] txPower,
  output logic       lnaHighGain,
  output logic       bankSel
);
  logic              sckRise;
  logic              sckFall;
  logic              csHigh;
  logic              csFall;
  logic              mosiBit;
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] rdData;
  logic [7:0]        retryReg;
  logic [6:0]        chanReg;
  logic [5:0]        rfReg;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .mosiIn(mosi),
    .sckRise(sckRise), .sckFall(sckFall), .csHigh(csHigh), .csFall(csFall), .mosiBit(mosiBit)
  );

  spi_xfer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall), .csHigh(csHigh),
    .csFall(csFall), .mosiBit(mosiBit), .statusByte(statusByte), .rdData(rdData),
    .strobe(strobe), .miso(miso)
  );

  cfg_reg_datapath #(
    .CHAN_RESET(CHAN_RESET), .RETRY_RESET(RETRY_RESET), .RF_RESET(RF_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxReadyEvt(rxReadyEvt),
    .maxRetryEvt(maxRetryEvt), .rxPipe(rxPipe), .txFull(txFull),
    .statusByte(statusByte), .rdData(rdData), .retryReg(retryReg),
    .chanReg(chanReg), .rfReg(rfReg), .bank(bankSel)
  );

  assign retryDelay  = retryReg[7:4];
  assign retryCount  = retryReg[3:0];
  assign channel     = chanReg;
  assign dataRate    = {rfReg[5], rfReg[3]};
  assign pllForce    = rfReg[4];
  assign txPower     = rfReg[2:1];
  assign lnaHighGain = rfReg[0];
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb_top;
  localparam int HALF = 6;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN, sck, csN, mosi, rxReadyEvt, maxRetryEvt, txFull;
  logic [2:0] rxPipe;
  logic miso, pllForce, lnaHighGain, bankSel;
  logic [3:0] retryDelay, retryCount;
  logic [6:0] channel;
  logic [1:0] dataRate, txPower;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [15:0] rxWord;
  logic expRx, expMax, expBank;

  always #2 clk = ~clk;

  spi_regport #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .rxReadyEvt(rxReadyEvt), .maxRetryEvt(maxRetryEvt), .rxPipe(rxPipe), .txFull(txFull),
    .miso(miso), .retryDelay(retryDelay), .retryCount(retryCount), .channel(channel),
    .dataRate(dataRate), .pllForce(pllForce), .txPower(txPower),
    .lnaHighGain(lnaHighGain), .bankSel(bankSel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // evtOffset > 0 pulses rxReadyEvt over the given clk edge after the final SCK rise
  task automatic xfer(input logic [15:0] outWord, input int nBits, input int evtOffset);
    rxWord = '0;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nBits; b++) begin
      mosi = outWord[15-b];
      repeat (HALF) @(negedge clk);
      rxWord = {rxWord[14:0], miso};
      sck = 1'b1;
      for (int c = 1; c <= HALF; c++) begin
        rxReadyEvt = (b == nBits-1) && (c == evtOffset);
        @(negedge clk);
      end
      rxReadyEvt = 1'b0;
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    xfer({3'b001, a, d}, 16, 0);
  endtask

  task automatic rdReg(input logic [4:0] a);
    xfer({3'b000, a, 8'h00}, 16, 0);
  endtask

  function automatic logic [7:0] expStatus();
    return {expBank, expRx, 1'b0, expMax, rxPipe, txFull};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; mosi = 1'b0;
    rxReadyEvt = 1'b0; maxRetryEvt = 1'b0; rxPipe = 3'b111; txFull = 1'b0;
    expRx = 1'b0; expMax = 1'b0; expBank = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R6 reset values at the ports
    chk("R4 retry reset", {8'h0, retryDelay, retryCount}, 16'h0003);
    chk("R4 chan reset", {9'h0, channel}, 16'h0002);
    chk("R6 rate reset", {14'h0, dataRate}, 16'h0001);
    chk("R6 rf fields reset", {12'h0, pllForce, txPower, lnaHighGain}, 16'h0007);

    // R1 status reset value
    xfer(16'hFF00, 16, 0);
    chk("R1 status reset", {8'h0, rxWord[15:8]}, 16'h000E);

    // R1 sweep live status inputs
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 2; f++) begin
        rxPipe = p[2:0]; txFull = f[0];
        xfer(16'hFF00, 16, 0);
        chk("R1 status sweep", {8'h0, rxWord[15:8]}, {8'h0, expStatus()});
      end
    end
    rxPipe = 3'b111; txFull = 1'b0;

    // R3 read reset values
    rdReg(5'h04); chk("R3 read retry", {8'h0, rxWord[7:0]}, 16'h0003);
    rdReg(5'h05); chk("R3 read chan", {8'h0, rxWord[7:0]}, 16'h0002);
    rdReg(5'h06); chk("R3 read rf", {8'h0, rxWord[7:0]}, 16'h000F);

    // R4 R5 channel sweep
    for (int v = 0; v < 256; v++) begin
      wrReg(5'h05, v[7:0]);
      chk("R4 R5 chan write", {9'h0, channel}, {9'h0, v[6:0]});
      if (v % 37 == 5) begin
        rdReg(5'h05);
        chk("R5 chan readback", {8'h0, rxWord[7:0]}, {8'h0, 1'b0, v[6:0]});
      end
    end

    // R6 R5 RF setup sweep
    for (int v = 0; v < 256; v++) begin
      wrReg(5'h06, v[7:0]);
      chk("R6 rf fields", {10'h0, dataRate, pllForce, txPower, lnaHighGain},
          {10'h0, v[5], v[3], v[4], v[2:1], v[0]});
      if (v % 41 == 7) begin
        rdReg(5'h06);
        chk("R5 rf readback", {8'h0, rxWord[7:0]}, {8'h0, 2'b00, v[5:0]});
      end
    end

    // R3 R4 retry setup
    for (int v = 0; v < 256; v += 51) begin
      wrReg(5'h04, v[7:0]);
      chk("R4 retry fields", {8'h0, retryDelay, retryCount}, {8'h0, v[7:0]});
      rdReg(5'h04);
      chk("R3 retry readback", {8'h0, rxWord[7:0]}, {8'h0, v[7:0]});
    end

    // R7 flags set and write-1-to-clear
    @(negedge clk); rxReadyEvt = 1'b1; @(negedge clk); rxReadyEvt = 1'b0;
    maxRetryEvt = 1'b1; @(negedge clk); maxRetryEvt = 1'b0;
    expRx = 1'b1; expMax = 1'b1;
    rdReg(5'h07); chk("R7 flags set", {8'h0, rxWord[15:8]}, {8'h0, expStatus()});
    wrReg(5'h07, 8'h00);
    rdReg(5'h07); chk("R7 zero write keeps", {8'h0, rxWord[7:0]}, {8'h0, expStatus()});
    wrReg(5'h07, 8'h10); expMax = 1'b0;
    rdReg(5'h07); chk("R7 clear max only", {8'h0, rxWord[7:0]}, {8'h0, expStatus()});
    wrReg(5'h07, 8'hEF); expRx = 1'b0;
    rdReg(5'h07); chk("R7 clear rx others ignored", {8'h0, rxWord[7:0]}, {8'h0, expStatus()});

    // R8 event pulse swept across the clear strobe edge
    for (int j = 1; j <= 5; j++) begin
      xfer({3'b001, 5'h07, 8'h40}, 16, j);
      expRx = (j >= SYNC + 1);
      rdReg(5'h07);
      chk("R8 set over clear", {8'h0, rxWord[15:8]}, {8'h0, expStatus()});
      wrReg(5'h07, 8'h40); expRx = 1'b0;
    end

    // R9 activate handling
    xfer({8'h50, 8'h52}, 16, 0);
    chk("R9 wrong key", {15'h0, bankSel}, 16'h0000);
    xfer({8'h50, 8'h53}, 16, 0); expBank = 1'b1;
    chk("R9 key toggles", {15'h0, bankSel}, 16'h0001);
    xfer(16'hFF00, 16, 0);
    chk("R9 status bank bit", {8'h0, rxWord[15:8]}, {8'h0, expStatus()});

    // R10 bank 1 behaviour
    wrReg(5'h05, 8'h11);
    chk("R10 bank1 write ignored", {9'h0, channel}, {9'h0, 7'h7F});
    rdReg(5'h05); chk("R10 bank1 read zero", {8'h0, rxWord[7:0]}, 16'h0000);
    rdReg(5'h07); chk("R10 bank1 status", {8'h0, rxWord[7:0]}, {8'h0, expStatus()});
    xfer({8'h50, 8'h53}, 16, 0); expBank = 1'b0;
    chk("R9 toggle back", {15'h0, bankSel}, 16'h0000);
    rdReg(5'h01); chk("R10 unmapped read", {8'h0, rxWord[7:0]}, 16'h0000);

    // R11 aborted writes
    wrReg(5'h05, 8'h22);
    xfer({3'b001, 5'h05, 8'h7F}, 12, 0);
    chk("R11 abort mid data", {9'h0, channel}, 16'h0022);
    xfer({3'b001, 5'h05, 8'h7F}, 15, 0);
    chk("R11 abort at bit 15", {9'h0, channel}, 16'h0022);
    wrReg(5'h05, 8'h33);
    chk("R11 fresh after abort", {9'h0, channel}, 16'h0033);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule